// File: doc/BRIEF.md
# Horizontal Chroma 4:4:4 to 4:2:2 Decimator

The block takes a raster video stream in which every pixel carries unsigned luma, Cr and Cb on three separate buses. It returns full-rate luma together with one chroma bus that carries Cr and Cb on alternate valid pixels, which halves the horizontal chroma rate. Before decimation each chroma channel passes through a short low-pass FIR whose taps, coefficient width and padding value are fixed by parameters. The FIR history shifts on every clock. On cycles without valid input it takes in a fixed padding code, so the edges of each line see a known neighbourhood.

Luma, both syncs and the valid strobe travel through a delay line whose length equals the chroma path. Downstream logic therefore sees every field aligned with no further work. A parameter replaces the filter with plain sample dropping, which shortens the latency. The filtered result is rounded back to the input width. Overflow and underflow are flagged beside the data, and clipping is left to the logic that follows. A rising edge on vertical sync clears the filter history and the Cr/Cb phase.

Top module: `chroma_hdec`

## Requirements
- R1: valid_o, hsync_o, vsync_o and luma_o equal valid_i, hsync_i, vsync_i and luma_i delayed by NUM_TAPS+5 clocks in filter mode (8 with three taps). In drop mode the delay is 4 clocks.
- R2: While rst_ni is low, every output is 0.
- R3: Chroma slots alternate on valid pixels, Cr first. The first valid pixel after valid_i rises, or after a mid-line gap, carries Cr. The next valid pixel carries Cb, and the pattern continues.
- R4: In filter mode, the chroma value for a slot is the sum over i < NUM_TAPS of COEFS[i] times that slot's channel sample taken i clocks earlier. Index 0 is the current (newest) sample. COEFS entries at or beyond NUM_TAPS have no effect.
- R5: The sum is rounded by adding 2^(COEF_W-2) and shifting right arithmetically by COEF_W-1. chroma_o is the low DATA_W bits of that result.
- R6: A sample taken on a clock where valid_i is low enters the filter history as PAD_VAL.
- R7: sat_o is 1 exactly when valid_o is 1 and the rounded result is above 2^DATA_W-1 or below 0. sat_dir_o is 0 for overflow and 1 for underflow. Both are 0 in every other case.
- R8: A clock on which vsync_i is 1 and was 0 on the previous clock refills the filter history with PAD_VAL from the next clock on. It also makes the next valid pixel a Cr slot.
- R9: In drop mode, chroma_o for a valid slot is the raw cr_i (Cr slot) or cb_i (Cb slot) of that pixel, and sat_o and sat_dir_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel valid |
| hsync_i | input | 1 | Horizontal sync, high over the active line |
| vsync_i | input | 1 | Vertical sync, high in vertical blanking |
| luma_i | input | DATA_W | Luma sample |
| cr_i | input | DATA_W | Cr sample |
| cb_i | input | DATA_W | Cb sample |
| valid_o | output | 1 | Delayed valid |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |
| luma_o | output | DATA_W | Delayed luma |
| chroma_o | output | DATA_W | Interleaved Cr/Cb, Cr first |
| sat_o | output | 1 | Rounded result out of range |
| sat_dir_o | output | 1 | 0 overflow, 1 underflow |

## Verification
The bench drives odd-length lines and lines split by a mid-line valid gap. A design that kept counting phase across the gap, or that restarted only on hsync, would put Cb where Cr belongs. It raises vsync inside a valid run: a design that ignored the clear would keep stale history and phase in the filter output. It places coefficient ordering under test with an asymmetric kernel and junk entries past the tap count, so reversed taps or stray taps show up as wrong chroma values. Its data patterns drive the result past both ends of the output range, so a swapped or missing overflow/underflow flag is caught. Sideband delays for both the filter build and the drop build are compared on every clock.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int unsigned MAX_COEFS = 8;

  typedef int coef_tbl_t [MAX_COEFS];

  localparam coef_tbl_t DEFAULT_COEFS = '{1, 2, 1, 0, 0, 0, 0, 0};

  function automatic int unsigned path_latency(input bit drop, input int unsigned taps);
    return drop ? 4 : taps + 5;
  endfunction
endpackage

// File: rtl/crs_delay.sv
module crs_delay #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_pipe
    logic [DEPTH-1:0][WIDTH-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '0;
      end else begin
        pipe_q[0] <= d_i;
        for (int k = 1; k < DEPTH; k++) pipe_q[k] <= pipe_q[k-1];
      end
    end
    assign q_o = pipe_q[DEPTH-1];
  end
endmodule

// File: rtl/crs_phase_track.sv
module crs_phase_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic vsync_i,
  output logic cr_slot_o,
  output logic vs_rise_o
);
  logic valid_q, vs_q, cb_next_q;

  assign vs_rise_o = vsync_i & ~vs_q;
  // restart on Cr at every rising edge of valid
  assign cr_slot_o = (valid_i & ~valid_q) | ~cb_next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      vs_q      <= 1'b0;
      cb_next_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      vs_q    <= vsync_i;
      if (vs_rise_o)    cb_next_q <= 1'b0;
      else if (valid_i) cb_next_q <= cr_slot_o;
    end
  end
endmodule

// File: rtl/crs_tap_window.sv
module crs_tap_window #(
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       NUM_TAPS = 3,
  parameter logic [DATA_W-1:0] PAD_VAL  = '0
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [DATA_W-1:0]                 sample_i,
  input  logic                              clear_i,
  output logic [NUM_TAPS-1:0][DATA_W-1:0]   win_o
);
  if (NUM_TAPS > 1) begin : g_hist
    logic [NUM_TAPS-2:0][DATA_W-1:0] hist_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hist_q <= {(NUM_TAPS-1){PAD_VAL}};
      end else if (clear_i) begin
        hist_q <= {(NUM_TAPS-1){PAD_VAL}};
      end else begin
        hist_q[0] <= sample_i;
        for (int k = 1; k < NUM_TAPS - 1; k++) hist_q[k] <= hist_q[k-1];
      end
    end
    assign win_o = {hist_q, sample_i};
  end else begin : g_single
    assign win_o = sample_i;
  end
endmodule

// File: rtl/crs_mac_round.sv
module crs_mac_round import crs_pkg::*; #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_TAPS = 3,
  parameter int unsigned COEF_W   = 3,
  parameter coef_tbl_t   COEFS    = DEFAULT_COEFS
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_TAPS-1:0][DATA_W-1:0] win_i,
  output logic [DATA_W-1:0]               chroma_o,
  output logic                            over_o,
  output logic                            under_o
);
  localparam int unsigned ACC_W = DATA_W + COEF_W + $clog2(NUM_TAPS + 1) + 1;
  localparam int unsigned SHIFT = COEF_W - 1;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'((1 << SHIFT) >> 1);
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};

  logic signed [ACC_W-1:0] prod [NUM_TAPS];
  logic signed [ACC_W-1:0] sum, acc_q, rnd, shf;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam logic signed [ACC_W-1:0] K = ACC_W'(COEFS[i]);
    assign prod[i] = $signed({{(ACC_W-DATA_W){1'b0}}, win_i[i]}) * K;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NUM_TAPS; i++) sum = sum + prod[i];
  end

  assign rnd = acc_q + HALF;
  assign shf = rnd >>> SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      chroma_o <= '0;
      over_o   <= 1'b0;
      under_o  <= 1'b0;
    end else begin
      acc_q    <= sum;
      chroma_o <= shf[DATA_W-1:0];
      over_o   <= shf > MAXV;
      under_o  <= shf[ACC_W-1];
    end
  end
endmodule

// File: rtl/chroma_hdec.sv
module chroma_hdec import crs_pkg::*; #(
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       NUM_TAPS  = 3,
  parameter int unsigned       COEF_W    = 3,
  parameter coef_tbl_t         COEFS     = DEFAULT_COEFS,
  parameter bit                DROP_MODE = 1'b0,
  parameter logic [DATA_W-1:0] PAD_VAL   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [DATA_W-1:0] luma_i,
  input  logic [DATA_W-1:0] cr_i,
  input  logic [DATA_W-1:0] cb_i,
  output logic              valid_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [DATA_W-1:0] luma_o,
  output logic [DATA_W-1:0] chroma_o,
  output logic              sat_o,
  output logic              sat_dir_o
);
  localparam int unsigned LAT = path_latency(DROP_MODE, NUM_TAPS);

  logic cr_slot, vs_rise;
  logic sat_raw, dir_raw;

  crs_phase_track u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .vsync_i   (vsync_i),
    .cr_slot_o (cr_slot),
    .vs_rise_o (vs_rise)
  );

  crs_delay #(.WIDTH(DATA_W + 3), .DEPTH(LAT)) u_side_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({luma_i, hsync_i, vsync_i, valid_i}),
    .q_o    ({luma_o, hsync_o, vsync_o, valid_o})
  );

  if (DROP_MODE) begin : g_drop
    logic [DATA_W-1:0] pick;
    assign pick = cr_slot ? cr_i : cb_i;
    crs_delay #(.WIDTH(DATA_W), .DEPTH(LAT)) u_ch_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pick),
      .q_o    (chroma_o)
    );
    assign sat_raw = 1'b0;
    assign dir_raw = 1'b0;
  end else begin : g_fir
    logic [DATA_W-1:0] cr_s, cb_s, ch_r;
    logic [NUM_TAPS-1:0][DATA_W-1:0] cr_win, cb_win, sel_win;
    logic ov_r, un_r, ov_d, un_d;

    assign cr_s = valid_i ? cr_i : PAD_VAL;
    assign cb_s = valid_i ? cb_i : PAD_VAL;

    crs_tap_window #(.DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS), .PAD_VAL(PAD_VAL)) u_cr_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (cr_s),
      .clear_i  (vs_rise),
      .win_o    (cr_win)
    );

    crs_tap_window #(.DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS), .PAD_VAL(PAD_VAL)) u_cb_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (cb_s),
      .clear_i  (vs_rise),
      .win_o    (cb_win)
    );

    // one MAC serves both channels: only one slot is emitted per clock
    assign sel_win = cr_slot ? cr_win : cb_win;

    crs_mac_round #(.DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W), .COEFS(COEFS)) u_mac (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .win_i    (sel_win),
      .chroma_o (ch_r),
      .over_o   (ov_r),
      .under_o  (un_r)
    );

    crs_delay #(.WIDTH(DATA_W + 2), .DEPTH(LAT - 2)) u_ch_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({ch_r, ov_r, un_r}),
      .q_o    ({chroma_o, ov_d, un_d})
    );

    assign sat_raw = ov_d | un_d;
    assign dir_raw = un_d;
  end

  assign sat_o     = sat_raw & valid_o;
  assign sat_dir_o = dir_raw & valid_o;
endmodule

// File: rtl/chroma_hdec_chk.sv
module chroma_hdec_chk #(
  parameter int unsigned LAT       = 8,
  parameter bit          DROP_MODE = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic valid_o,
  input logic sat_o,
  input logic sat_dir_o,
  input logic cr_slot_i,
  input logic vs_rise_i
);
  logic pv_q, pcr_q, pvr_q;
  logic [LAT-1:0] vline_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q    <= 1'b0;
      pcr_q   <= 1'b0;
      pvr_q   <= 1'b0;
      vline_q <= '0;
    end else begin
      pv_q    <= valid_i;
      pcr_q   <= valid_i & cr_slot_i;
      pvr_q   <= vs_rise_i;
      vline_q <= {vline_q[LAT-2:0], valid_i};
    end
  end

  // R3
  first_cr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pv_q) |-> cr_slot_i);

  // R3
  alt_cb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pv_q && pcr_q && !pvr_q) |-> !cr_slot_i);

  // R8
  vs_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pvr_q && valid_i) |-> cr_slot_i);

  // R7
  sat_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> valid_o);

  // R7
  sat_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_dir_o |-> sat_o);

  // R9
  drop_nosat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    DROP_MODE |-> !sat_o);

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vline_q[LAT-1]);
endmodule

bind chroma_hdec chroma_hdec_chk #(.LAT(LAT), .DROP_MODE(DROP_MODE)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .valid_o   (valid_o),
  .sat_o     (sat_o),
  .sat_dir_o (sat_dir_o),
  .cr_slot_i (cr_slot),
  .vs_rise_i (vs_rise)
);

// File: tb/test_chroma_hdec.sv
`timescale 1ns/1ps
module test_chroma_hdec;
  import crs_pkg::*;

  localparam logic [7:0] PAD = 8'd16;
  localparam int LF = 8;
  localparam int LD = 4;
  localparam coef_tbl_t MAIN_K = '{1, 2, 1, 7, 7, 7, 7, 7};
  localparam coef_tbl_t SAT_K  = '{-1, 5, 4, 9, 9, 9, 9, 9};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic valid_i = 0, hsync_i = 0, vsync_i = 0;
  logic [7:0] luma_i = 0, cr_i = 0, cb_i = 0;

  logic m_v, m_h, m_vs, m_sat, m_dir; logic [7:0] m_y, m_ch;
  logic s_v, s_h, s_vs, s_sat, s_dir; logic [7:0] s_y, s_ch;
  logic d_v, d_h, d_vs, d_sat, d_dir; logic [7:0] d_y, d_ch;

  chroma_hdec #(.COEF_W(3), .COEFS(MAIN_K), .PAD_VAL(PAD)) i_chroma_hdec (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .luma_i(luma_i), .cr_i(cr_i), .cb_i(cb_i), .valid_o(m_v), .hsync_o(m_h), .vsync_o(m_vs),
    .luma_o(m_y), .chroma_o(m_ch), .sat_o(m_sat), .sat_dir_o(m_dir));

  chroma_hdec #(.COEF_W(4), .COEFS(SAT_K), .PAD_VAL(PAD)) i_chroma_hdec_sat (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .luma_i(luma_i), .cr_i(cr_i), .cb_i(cb_i), .valid_o(s_v), .hsync_o(s_h), .vsync_o(s_vs),
    .luma_o(s_y), .chroma_o(s_ch), .sat_o(s_sat), .sat_dir_o(s_dir));

  chroma_hdec #(.DROP_MODE(1'b1), .PAD_VAL(PAD)) i_chroma_hdec_drop (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .luma_i(luma_i), .cr_i(cr_i), .cb_i(cb_i), .valid_o(d_v), .hsync_o(d_h), .vsync_o(d_vs),
    .luma_o(d_y), .chroma_o(d_ch), .sat_o(d_sat), .sat_dir_o(d_dir));

  int checks = 0, failures = 0, j = 0;
  string tag = "R4";

  logic [7:0] e_y [16], e_ch [16], e_chs [16], e_chd [16];
  bit e_h [16], e_vs [16], e_v [16], e_sat [16], e_dir [16];

  int h_cr [2], h_cb [2];
  bit mv_q = 0, mvs_q = 0, mph_q = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle=%0d got=%0h exp=%0h", req, j, got, exp);
    end
  endtask

  function automatic longint fir(input coef_tbl_t k, input int cw, input int a0, input int a1, input int a2);
    longint acc = longint'(k[0]) * a0 + longint'(k[1]) * a1 + longint'(k[2]) * a2;
    longint half = longint'((1 << (cw - 1)) >> 1);
    return (acc + half) >>> (cw - 1);
  endfunction

  task automatic check_all();
    int km = (j - LF) & 15;
    int kd = (j - LD) & 15;
    chk({m_y, m_h, m_vs, m_v} == {e_y[km], e_h[km], e_vs[km], e_v[km]}, "R1",
        {m_y, m_h, m_vs, m_v}, {e_y[km], e_h[km], e_vs[km], e_v[km]});
    chk({s_y, s_h, s_vs, s_v} == {e_y[km], e_h[km], e_vs[km], e_v[km]}, "R1",
        {s_y, s_h, s_vs, s_v}, {e_y[km], e_h[km], e_vs[km], e_v[km]});
    chk({d_y, d_h, d_vs, d_v} == {e_y[kd], e_h[kd], e_vs[kd], e_v[kd]}, "R1",
        {d_y, d_h, d_vs, d_v}, {e_y[kd], e_h[kd], e_vs[kd], e_v[kd]});
    if (e_v[km]) begin
      chk(m_ch == e_ch[km], tag, m_ch, e_ch[km]);
      chk(s_ch == e_chs[km], "R5", s_ch, e_chs[km]);
    end
    chk({m_sat, m_dir} == 2'b00, "R7", {m_sat, m_dir}, 0);
    chk({s_sat, s_dir} == {e_sat[km], e_dir[km]}, "R7", {s_sat, s_dir}, {e_sat[km], e_dir[km]});
    if (e_v[kd]) chk(d_ch == e_chd[kd], "R9", d_ch, e_chd[kd]);
    chk({d_sat, d_dir} == 2'b00, "R9", {d_sat, d_dir}, 0);
  endtask

  task automatic model(input bit v, input bit h, input bit vs, input logic [7:0] y, input logic [7:0] r, input logic [7:0] b);
    int k = j & 15;
    int acr = v ? int'(r) : int'(PAD);
    int acb = v ? int'(b) : int'(PAD);
    bit cur = (v && !mv_q) || !mph_q;
    bit rise = vs && !mvs_q;
    longint fm, fs;
    if (cur) begin
      fm = fir(MAIN_K, 3, acr, h_cr[0], h_cr[1]);
      fs = fir(SAT_K, 4, acr, h_cr[0], h_cr[1]);
    end else begin
      fm = fir(MAIN_K, 3, acb, h_cb[0], h_cb[1]);
      fs = fir(SAT_K, 4, acb, h_cb[0], h_cb[1]);
    end
    e_y[k] = y; e_h[k] = h; e_vs[k] = vs; e_v[k] = v;
    e_ch[k]  = 8'(fm);
    e_chs[k] = 8'(fs);
    e_sat[k] = v && (fs > 255 || fs < 0);
    e_dir[k] = v && (fs < 0);
    e_chd[k] = cur ? r : b;
    if (rise) begin
      h_cr = '{int'(PAD), int'(PAD)}; h_cb = '{int'(PAD), int'(PAD)};
    end else begin
      h_cr[1] = h_cr[0]; h_cr[0] = acr;
      h_cb[1] = h_cb[0]; h_cb[0] = acb;
    end
    if (rise) mph_q = 1'b0;
    else if (v) mph_q = cur;
    mv_q = v; mvs_q = vs;
  endtask

  task automatic step(input bit v, input bit h, input bit vs, input logic [7:0] y, input logic [7:0] r, input logic [7:0] b);
    @(negedge clk);
    check_all();
    valid_i = v; hsync_i = h; vsync_i = vs; luma_i = y; cr_i = r; cb_i = b;
    model(v, h, vs, y, r, b);
    j++;
  endtask

  task automatic rand_line(input int len);
    for (int p = 0; p < len; p++) begin
      if (($urandom % 10) == 0) begin
        for (int g = 0; g < 1 + int'($urandom % 3); g++) step(0, 1, 0, 8'($urandom), 8'($urandom), 8'($urandom));
      end
      step(1, 1, 0, 8'($urandom), 8'($urandom), 8'($urandom));
    end
  endtask

  initial begin
    logic [7:0] sat_pat [8] = '{8'd0, 8'd0, 8'd255, 8'd255, 8'd255, 8'd0, 8'd0, 8'd255};
    void'($urandom(32'd4242));
    h_cr = '{int'(PAD), int'(PAD)}; h_cb = '{int'(PAD), int'(PAD)};
    for (int k = 0; k < 16; k++) begin
      e_y[k] = 0; e_h[k] = 0; e_vs[k] = 0; e_v[k] = 0;
      e_ch[k] = 0; e_chs[k] = 0; e_chd[k] = 0; e_sat[k] = 0; e_dir[k] = 0;
    end
    valid_i = 1; hsync_i = 1; vsync_i = 1; luma_i = 8'hA5; cr_i = 8'h5A; cb_i = 8'h3C;
    repeat (3) @(negedge clk);
    // R2: reset holds every output at zero
    chk({m_y, m_ch, m_v, m_h, m_vs, m_sat, m_dir} == '0, "R2", {m_y, m_ch, m_v, m_h, m_vs}, 0);
    chk({s_y, s_ch, s_v, s_h, s_vs, s_sat, s_dir} == '0, "R2", {s_y, s_ch, s_v, s_h, s_vs}, 0);
    chk({d_y, d_ch, d_v, d_h, d_vs, d_sat, d_dir} == '0, "R2", {d_y, d_ch, d_v, d_h, d_vs}, 0);
    valid_i = 0; hsync_i = 0; vsync_i = 0; luma_i = 0; cr_i = 0; cb_i = 0;
    rst_ni = 1'b1;
    repeat (10) step(0, 0, 0, 0, 0, 0);

    tag = "R3";
    for (int p = 0; p < 7; p++) step(1, 1, 0, 8'(p * 3), 8'(40 + p * 10), 8'(200 - p * 9));
    repeat (4) step(0, 0, 0, 0, 0, 0);
    for (int p = 0; p < 5; p++) step(1, 1, 0, 8'(p), 8'(90 + p), 8'(30 + p));
    repeat (2) step(0, 1, 0, 0, 0, 0);
    for (int p = 0; p < 5; p++) step(1, 1, 0, 8'(p), 8'(120 - p), 8'(60 + p));
    repeat (4) step(0, 0, 0, 0, 0, 0);

    tag = "R6";
    step(1, 1, 0, 8'd77, 8'd250, 8'd5);
    step(1, 1, 0, 8'd78, 8'd250, 8'd5);
    repeat (4) step(0, 0, 0, 0, 0, 0);

    tag = "R8";
    for (int p = 0; p < 10; p++) step(1, 1, p >= 5, 8'(p), 8'(20 + p * 20), 8'(230 - p * 20));
    repeat (3) step(0, 0, 1, 0, 0, 0);
    repeat (3) step(0, 0, 0, 0, 0, 0);

    tag = "R4";
    for (int p = 0; p < 8; p++) step(1, 1, 0, 8'(p), sat_pat[p], sat_pat[p]);
    repeat (4) step(0, 0, 0, 0, 0, 0);

    for (int ln = 0; ln < 150; ln++) begin
      if ((ln % 25) == 24) repeat (3) step(0, 0, 1, 0, 0, 0);
      for (int g = 0; g < 1 + int'($urandom % 5); g++) step(0, 0, 0, 8'($urandom), 8'($urandom), 8'($urandom));
      rand_line(1 + int'($urandom % 40));
    end
    repeat (12) step(0, 0, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule